// File: doc/BRIEF.md
# DMA Coherence Request Controller

This block is the front end of a DMA engine in a cache-coherent memory system. It keeps exactly one transaction outstanding at a time. A load or store arrives from the DMA sequencer and becomes a read or write request message to the directory. The controller then consumes the directory's responses: data, invalidation acknowledgements and write acknowledgements. When the transaction is finished it reports completion back to the sequencer.

Completion is tracked by a signed pending-acknowledgement counter. Invalidation acks subtract their count field from it. A write acknowledgement carries a negative field, so it raises the count. Whenever an update leaves the counter at zero, an internal completion trigger is raised, and it is served on a later cycle ahead of any directory response. A finished write also returns an exclusive-unblock message to the directory on its own channel.

Both outgoing channels are valid/ready. Each message becomes visible a fixed number of cycles after it is launched, and it stays stable until the receiver takes it.

Top module: `dma_coh_ctl`

## Requirements
- R1: After reset the controller is idle, with `seq_ready` high. A request is accepted only when idle and the request channel is empty. `seq_ready` is low from the cycle after an acceptance until the transaction completes.
- R2: An accepted load produces a directory request with `dreq_is_write`=0 and the request's address, data and length. An accepted store produces the same with `dreq_is_write`=1.
- R3: `rsp_type` is decoded as follows: 0 and 1 are data, 2 is an invalidation ack, 3 is a write ack, and 4 to 7 are illegal.
- R4: The signed pending counter is cleared on acceptance. Each legal ack response replaces it with counter minus `rsp_acks`. If the result is zero, a completion trigger becomes pending.
- R5: While reading, a data response pulses `rd_done` one cycle after it is consumed, with `rd_data` equal to the response data, and the controller returns to idle. A completion trigger instead returns the stored block, which is cleared to zero on acceptance.
- R6: While writing, a completion trigger pulses `wr_done` and launches an unblock message. That message carries the request address with its low `LINE_BITS` bits cleared.
- R7: When a trigger is pending, `rsp_ready` is low. When idle with `seq_valid` high, `rsp_ready` is also low. At most one input message is consumed per cycle.
- R8: An outgoing message launched in cycle n is first valid in cycle n+`LAT`.
- R9: `err` is set and stays set when any of these is consumed: an illegal type, data while writing, a write ack while not writing, or any response while idle. Such a response causes no state change.
- R10: A waiting output message holds its valid and fields until it is taken. A write completion waits while a previous unblock message is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_valid | input | 1 | Sequencer request offered |
| seq_ready | output | 1 | Sequencer request accepted |
| seq_is_store | input | 1 | 1 = store, 0 = load |
| seq_addr | input | ADDR_W | Physical address |
| seq_data | input | DATA_W | Data block |
| seq_len | input | LEN_W | Transfer length |
| dreq_valid | output | 1 | Directory request valid |
| dreq_ready | input | 1 | Directory request taken |
| dreq_is_write | output | 1 | 1 = DMA write, 0 = DMA read |
| dreq_addr | output | ADDR_W | Request address |
| dreq_data | output | DATA_W | Request data block |
| dreq_len | output | LEN_W | Request length |
| rsp_valid | input | 1 | Directory response offered |
| rsp_ready | output | 1 | Directory response consumed |
| rsp_type | input | 3 | Response type code (R3) |
| rsp_acks | input | ACK_W | Signed ack count field |
| rsp_data | input | DATA_W | Response data block |
| unblk_valid | output | 1 | Unblock message valid |
| unblk_ready | input | 1 | Unblock message taken |
| unblk_addr | output | ADDR_W | Line address of the unblock |
| rd_done | output | 1 | Read completion pulse |
| rd_data | output | DATA_W | Read completion data |
| wr_done | output | 1 | Write completion pulse |
| err | output | 1 | Sticky protocol error flag |

## Verification
The assertions check on every cycle that an accepted request drops `seq_ready`, and that only one input is consumed per cycle. They also check that a pending trigger blocks responses, that a zero counter result raises the trigger, that waiting output messages hold, that a write completion has its unblock in flight, and that the error flag is sticky. The exact latency, the decoding of each type code, the signed counter passing through negative values, the returned data, and the stall of a write completion behind an unaccepted unblock can only be shown by the bench's scenarios. The bench compares them against its cycle model.

// File: rtl/dma_coh_pkg.sv
package dma_coh_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} dma_st_e;
  typedef enum logic [2:0] {EV_NONE, EV_DATA, EV_INV, EV_WRACK, EV_BAD} dma_ev_e;

  localparam logic [2:0] RSP_DATA      = 3'd0;
  localparam logic [2:0] RSP_DATA_EXCL = 3'd1;
  localparam logic [2:0] RSP_INV_ACK   = 3'd2;
  localparam logic [2:0] RSP_WR_ACK    = 3'd3;

  function automatic dma_ev_e decode_rsp(input logic [2:0] t);
    case (t)
      RSP_DATA, RSP_DATA_EXCL: return EV_DATA;
      RSP_INV_ACK:             return EV_INV;
      RSP_WR_ACK:              return EV_WRACK;
      default:                 return EV_BAD;
    endcase
  endfunction
endpackage

// File: rtl/dma_out_chan.sv
module dma_out_chan #(
  parameter int W   = 8,
  parameter int LAT = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_msg,
  output logic         busy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_msg
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

  logic          full_q;
  logic [CW-1:0] wait_q;
  logic [W-1:0]  msg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      wait_q <= '0;
      msg_q  <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      wait_q <= CW'(LAT - 1);
      msg_q  <= load_msg;
    end else if (full_q && wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end else if (out_valid && out_ready) begin
      full_q <= 1'b0;
    end
  end

  assign busy      = full_q;
  assign out_valid = full_q && (wait_q == '0);
  assign out_msg   = msg_q;
endmodule

// File: rtl/dma_ack_tracker.sv
module dma_ack_tracker #(
  parameter int ACK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    upd,
  input  logic signed [ACK_W-1:0] ack_in,
  input  logic                    fire,
  output logic                    trig_pend,
  output logic                    hit_zero
);
  function automatic logic signed [ACK_W-1:0] ack_next(
    input logic signed [ACK_W-1:0] cur,
    input logic signed [ACK_W-1:0] delta);
    return cur - delta;
  endfunction

  logic signed [ACK_W-1:0] cnt_q;
  logic signed [ACK_W-1:0] cnt_nxt;

  assign cnt_nxt  = ack_next(cnt_q, ack_in);
  assign hit_zero = upd && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      trig_pend <= 1'b0;
    end else begin
      if (clear)    cnt_q <= '0;
      else if (upd) cnt_q <= cnt_nxt;
      if (hit_zero)  trig_pend <= 1'b1;
      else if (fire) trig_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_coh_ctl.sv
module dma_coh_ctl
  import dma_coh_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 8,
  parameter int ACK_W     = 8,
  parameter int LAT       = 14,
  parameter int LINE_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seq_valid,
  output logic                    seq_ready,
  input  logic                    seq_is_store,
  input  logic [ADDR_W-1:0]       seq_addr,
  input  logic [DATA_W-1:0]       seq_data,
  input  logic [LEN_W-1:0]        seq_len,
  output logic                    dreq_valid,
  input  logic                    dreq_ready,
  output logic                    dreq_is_write,
  output logic [ADDR_W-1:0]       dreq_addr,
  output logic [DATA_W-1:0]       dreq_data,
  output logic [LEN_W-1:0]        dreq_len,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic [2:0]              rsp_type,
  input  logic signed [ACK_W-1:0] rsp_acks,
  input  logic [DATA_W-1:0]       rsp_data,
  output logic                    unblk_valid,
  input  logic                    unblk_ready,
  output logic [ADDR_W-1:0]       unblk_addr,
  output logic                    rd_done,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    wr_done,
  output logic                    err
);
  localparam int REQ_W = 1 + ADDR_W + DATA_W + LEN_W;

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return (a >> LINE_BITS) << LINE_BITS;
  endfunction

  dma_st_e           st_q;
  logic [ADDR_W-1:0] line_q;
  logic [DATA_W-1:0] blk_q;
  logic              err_q, rd_done_q, wr_done_q;
  logic [DATA_W-1:0] rd_data_q;

  // named internal events
  logic    req_busy, ub_busy, trig_pend, ack_zero;
  logic    seq_fire, rsp_fire, serve_rd, serve_wr, trig_fire;
  logic    ev_data_ok, ack_upd, ev_bad;
  dma_ev_e ev;
  logic [REQ_W-1:0] req_msg;

  assign seq_ready = (st_q == ST_IDLE) && !req_busy;
  assign seq_fire  = seq_valid && seq_ready;
  assign rsp_ready = !trig_pend && !((st_q == ST_IDLE) && seq_valid);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign ev        = rsp_fire ? decode_rsp(rsp_type) : EV_NONE;

  assign serve_rd   = trig_pend && (st_q == ST_RD);
  assign serve_wr   = trig_pend && (st_q == ST_WR) && !ub_busy;
  assign trig_fire  = serve_rd || serve_wr;
  assign ev_data_ok = (ev == EV_DATA) && (st_q == ST_RD);
  assign ack_upd    = ((ev == EV_INV) && (st_q != ST_IDLE)) ||
                      ((ev == EV_WRACK) && (st_q == ST_WR));
  assign ev_bad     = rsp_fire && !ev_data_ok && !ack_upd;

  dma_ack_tracker #(.ACK_W(ACK_W)) u_acks (
    .clk(clk), .rst_n(rst_n), .clear(seq_fire), .upd(ack_upd),
    .ack_in(rsp_acks), .fire(trig_fire), .trig_pend(trig_pend), .hit_zero(ack_zero)
  );

  dma_out_chan #(.W(REQ_W), .LAT(LAT)) u_req_chan (
    .clk(clk), .rst_n(rst_n), .load(seq_fire),
    .load_msg({seq_is_store, seq_addr, seq_data, seq_len}),
    .busy(req_busy), .out_valid(dreq_valid), .out_ready(dreq_ready), .out_msg(req_msg)
  );
  assign {dreq_is_write, dreq_addr, dreq_data, dreq_len} = req_msg;

  dma_out_chan #(.W(ADDR_W), .LAT(LAT)) u_ub_chan (
    .clk(clk), .rst_n(rst_n), .load(serve_wr), .load_msg(line_q),
    .busy(ub_busy), .out_valid(unblk_valid), .out_ready(unblk_ready), .out_msg(unblk_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      line_q    <= '0;
      blk_q     <= '0;
      err_q     <= 1'b0;
      rd_done_q <= 1'b0;
      wr_done_q <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_done_q <= ev_data_ok || serve_rd;
      wr_done_q <= serve_wr;
      if (ev_bad) err_q <= 1'b1;
      if (ev_data_ok) begin
        rd_data_q <= rsp_data;
        blk_q     <= rsp_data;
      end else if (serve_rd) begin
        rd_data_q <= blk_q;
      end
      case (st_q)
        ST_IDLE: if (seq_fire) begin
          st_q   <= seq_is_store ? ST_WR : ST_RD;
          line_q <= line_of(seq_addr);
          blk_q  <= '0;
        end
        ST_RD: if (ev_data_ok || serve_rd) st_q <= ST_IDLE;
        ST_WR: if (serve_wr) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_done = rd_done_q;
  assign rd_data = rd_data_q;
  assign wr_done = wr_done_q;
  assign err     = err_q;
endmodule

// File: rtl/dma_coh_ctl_chk.sv
module dma_coh_ctl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_valid,
  input logic              seq_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              dreq_valid,
  input logic              dreq_ready,
  input logic              dreq_is_write,
  input logic [ADDR_W-1:0] dreq_addr,
  input logic              unblk_valid,
  input logic              unblk_ready,
  input logic [ADDR_W-1:0] unblk_addr,
  input logic              rd_done,
  input logic              wr_done,
  input logic              err,
  input logic              trig_pend,
  input logic              ack_upd,
  input logic              ack_zero,
  input logic              ub_busy
);
  assert_accept_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && seq_ready |=> !seq_ready);
  assert_zero_triggers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_upd && ack_zero |=> trig_pend);
  assert_done_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_done && wr_done));
  assert_unblock_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ub_busy);
  assert_trigger_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pend |-> !rsp_ready);
  assert_one_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_valid && seq_ready && rsp_valid && rsp_ready));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_addr) && $stable(dreq_is_write));
  assert_unblk_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unblk_valid && !unblk_ready |=> unblk_valid && $stable(unblk_addr));
endmodule

bind dma_coh_ctl dma_coh_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_valid(seq_valid), .seq_ready(seq_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .dreq_valid(dreq_valid),
  .dreq_ready(dreq_ready), .dreq_is_write(dreq_is_write), .dreq_addr(dreq_addr),
  .unblk_valid(unblk_valid), .unblk_ready(unblk_ready), .unblk_addr(unblk_addr),
  .rd_done(rd_done), .wr_done(wr_done), .err(err), .trig_pend(trig_pend),
  .ack_upd(ack_upd), .ack_zero(ack_zero), .ub_busy(ub_busy)
);

// File: tb/tb_dma_coh_ctl.sv
module tb_dma_coh_ctl;
  localparam int LAT = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        seq_valid = 0, seq_is_store = 0;
  logic [31:0] seq_addr = 0;
  logic [63:0] seq_data = 0;
  logic [7:0]  seq_len = 0;
  logic        dreq_ready = 1, rsp_valid = 0, unblk_ready = 1;
  logic [2:0]  rsp_type = 0;
  logic signed [7:0] rsp_acks = 0;
  logic [63:0] rsp_data = 0;
  logic        seq_ready, dreq_valid, dreq_is_write, rsp_ready, unblk_valid;
  logic        rd_done, wr_done, err;
  logic [31:0] dreq_addr, unblk_addr;
  logic [63:0] dreq_data, rd_data;
  logic [7:0]  dreq_len;

  dma_coh_ctl #(.LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .seq_valid(seq_valid), .seq_ready(seq_ready),
    .seq_is_store(seq_is_store), .seq_addr(seq_addr), .seq_data(seq_data), .seq_len(seq_len),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_is_write(dreq_is_write),
    .dreq_addr(dreq_addr), .dreq_data(dreq_data), .dreq_len(dreq_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type), .rsp_acks(rsp_acks),
    .rsp_data(rsp_data), .unblk_valid(unblk_valid), .unblk_ready(unblk_ready),
    .unblk_addr(unblk_addr), .rd_done(rd_done), .rd_data(rd_data), .wr_done(wr_done), .err(err)
  );

  int errors = 0, checks = 0;

  // behavioural model: 0 idle, 1 reading, 2 writing
  int n = 0, m_st = 0, m_cnt = 0;
  bit m_trig = 0, m_err = 0, m_rd = 0, m_wr = 0;
  longint m_blk = 0, m_rdd = 0;
  bit req_has = 0, req_wr = 0; int req_due = 0;
  longint req_addr = 0, req_data = 0, req_len = 0;
  bit ub_has = 0; int ub_due = 0; longint ub_addr = 0, m_line = 0;
  bit last_seq_fire = 0, last_rsp_fire = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", what, n, act, exp);
    end
  endtask

  task automatic cyc();
    bit s_rdy, r_rdy, dv, uv, f_seq, f_rsp, rel_req, rel_ub, srv_rd, srv_wr, nrd, nwr;
    #1;
    s_rdy = (m_st == 0) && !req_has;
    r_rdy = !m_trig && !((m_st == 0) && seq_valid);
    dv = req_has && (n >= req_due);
    uv = ub_has && (n >= ub_due);
    chk(seq_ready == s_rdy, "R1 seq_ready", seq_ready, s_rdy);
    chk(rsp_ready == r_rdy, "R7 rsp_ready", rsp_ready, r_rdy);
    chk(dreq_valid == dv, "R8,R10 dreq_valid", dreq_valid, dv);
    if (dv && dreq_valid)
      chk({dreq_is_write, dreq_addr, dreq_data, dreq_len} ==
          {req_wr, req_addr[31:0], req_data[63:0], req_len[7:0]},
          "R2 dreq fields", dreq_addr, req_addr);
    chk(unblk_valid == uv, "R6,R8 unblk_valid", unblk_valid, uv);
    if (uv && unblk_valid) chk(unblk_addr == ub_addr[31:0], "R6 unblk_addr", unblk_addr, ub_addr);
    chk(rd_done == m_rd, "R3,R5 rd_done", rd_done, m_rd);
    if (m_rd && rd_done) chk(rd_data == m_rdd[63:0], "R5 rd_data", rd_data, m_rdd);
    chk(wr_done == m_wr, "R4,R6 wr_done", wr_done, m_wr);
    chk(err == m_err, "R3,R9 err", err, m_err);

    f_seq = seq_valid && s_rdy;
    f_rsp = rsp_valid && r_rdy;
    rel_req = dv && dreq_ready;
    rel_ub = uv && unblk_ready;
    srv_rd = m_trig && m_st == 1;
    srv_wr = m_trig && m_st == 2 && !ub_has;
    nrd = 0; nwr = 0;
    @(posedge clk);
    if (rel_req) req_has = 0;
    if (rel_ub) ub_has = 0;
    if (f_seq) begin
      req_has = 1; req_due = n + LAT; req_wr = seq_is_store;
      req_addr = seq_addr; req_data = seq_data; req_len = seq_len;
      m_st = seq_is_store ? 2 : 1; m_cnt = 0; m_blk = 0;
      m_line = (seq_addr / 64) * 64;
    end
    if (srv_rd) begin nrd = 1; m_rdd = m_blk; m_st = 0; m_trig = 0; end
    if (srv_wr) begin
      nwr = 1; ub_has = 1; ub_due = n + LAT; ub_addr = m_line; m_st = 0; m_trig = 0;
    end
    if (f_rsp) begin
      if (rsp_type <= 1 && m_st == 1) begin
        nrd = 1; m_rdd = rsp_data; m_blk = rsp_data; m_st = 0;
      end else if ((rsp_type == 2 && m_st != 0) || (rsp_type == 3 && m_st == 2)) begin
        m_cnt = m_cnt - int'(rsp_acks);
        if (m_cnt == 0) m_trig = 1;
      end else m_err = 1;
    end
    m_rd = nrd; m_wr = nwr;
    last_seq_fire = f_seq; last_rsp_fire = f_rsp;
    n++;
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    repeat (k) cyc();
  endtask

  task automatic seq_req(input bit st, input logic [31:0] a, input logic [63:0] d, input logic [7:0] l);
    seq_is_store = st; seq_addr = a; seq_data = d; seq_len = l; seq_valid = 1;
    forever begin cyc(); if (last_seq_fire) break; end
    seq_valid = 0;
  endtask

  task automatic rsp(input logic [2:0] t, input int acks, input logic [63:0] d);
    rsp_type = t; rsp_acks = 8'(acks); rsp_data = d; rsp_valid = 1;
    forever begin cyc(); if (last_rsp_fire) break; end
    rsp_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);                                       // R1 reset state
    // R2/R8/R10: load with request held back, then DATA
    dreq_ready = 0;
    seq_req(0, 32'h0000_1234, 64'hAAAA_0001, 8'd16);
    idle(LAT + 4);
    dreq_ready = 1;
    idle(2);
    rsp(3'd0, 0, 64'hDEAD_BEEF_0000_0001);         // R3/R5 data
    idle(3);
    // DATA_EXCLUSIVE completes a read too
    seq_req(0, 32'h0000_2040, 64'h5, 8'd8);
    idle(LAT + 1);
    rsp(3'd1, 0, 64'h1234_5678_9ABC_DEF0);
    idle(2);
    // R4/R5: read finished by trigger, returns cleared block
    seq_req(0, 32'h0000_3000, 64'h7, 8'd4);
    idle(3);
    rsp(3'd2, 0, 64'hFFFF);
    idle(4);
    // R4/R6: write, write-ack raises count, two inv acks lower it
    seq_req(1, 32'h0000_40FF, 64'hCAFE, 8'd32);
    idle(LAT + 1);
    rsp(3'd3, -2, 0);
    rsp(3'd2, 1, 0);
    rsp(3'd2, 1, 0);
    idle(LAT + 3);
    // R4: counter through a negative value
    seq_req(1, 32'h0000_5080, 64'hBEEF, 8'd2);
    rsp(3'd2, 1, 0);
    rsp(3'd3, -2, 0);
    rsp(3'd2, 1, 0);
    idle(3);
    // R10: write completion waits behind an untaken unblock
    unblk_ready = 0;
    idle(LAT + 2);
    seq_req(1, 32'h0000_6100, 64'h1, 8'd1);
    rsp(3'd3, 0, 0);
    idle(20);
    unblk_ready = 1;
    idle(LAT + 4);
    // R7: response offered together with a request in idle
    rsp_valid = 1; rsp_type = 3'd2; rsp_acks = 8'sd5; rsp_data = 0;
    seq_req(0, 32'h0000_7000, 64'h2, 8'd2);
    forever begin cyc(); if (last_rsp_fire) break; end
    rsp_valid = 0;
    rsp(3'd0, 0, 64'h77);
    idle(2);
    // R9: illegal events consumed, no state change
    seq_req(0, 32'h0000_8000, 64'h3, 8'd3);
    rsp(3'd3, 0, 0);                               // write ack while reading
    rsp(3'd6, 0, 0);                               // illegal type
    rsp(3'd0, 0, 64'h99);                          // read still completes
    rsp(3'd1, 0, 64'h11);                          // data while idle
    seq_req(1, 32'h0000_9000, 64'h4, 8'd4);
    rsp(3'd0, 0, 64'h22);                          // data while writing
    rsp(3'd3, 0, 0);
    idle(LAT + 4);
    chk(err == 1'b1, "R9 err stays set", err, 1);
    chk(seq_ready == 1'b1, "R1 idle at end", seq_ready, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule